// File: doc/BRIEF.md
# Return-Address Hash Digest Unit

This block turns two 64-bit operands and a 64-bit secret key into a 64-bit tag. A processor uses the tag to protect a saved return address. First the bytes of the two operands are woven into two 64-bit staging words. Then each of the four 32-bit quarters of those words goes through a lightweight 32-round Feistel cipher. The cipher uses a 16-bit word size and a rotating-AND round function. Each quarter uses a different rotation of the round-key order. Finally the two enciphered 64-bit words are folded together with XOR.

The caller places the operands and the key on the inputs and raises `start` for one cycle. The unit captures everything at that edge, so the inputs are free to change afterwards. A single combinational cipher core is then reused for four consecutive cycles, once per quarter. The unit raises `done` for exactly one cycle with the finished `digest`. The digest output holds its value until the next computation completes.

Top module: `hashDigestUnit`

## Requirements
- R1: While `rstN` is low, `done` is 0 and `digest` is all zeros.
- R2: Staging word H holds byte i of `opB` (bits 8i+7:8i) at byte position 7−2i and byte 4+i of `opA` at byte position 2i, for i = 0..3.
- R3: Staging word L holds byte 4+i of `opB` at byte position 7−2i and byte i of `opA` at byte position 2i, for i = 0..3.
- R4: The cipher works on 16-bit halves: left = x[15:0], right = x[31:16].
  - Base round keys are k0 = key[63:48], k1 = key[47:32], k2 = key[31:16] and k3 = key[15:0].
  - For i = 0..27, with t = ror3(k[i+3]) ^ k[i+1], the next key is k[i+4] = 0xFFFC ^ z_i ^ k[i] ^ t ^ ror1(t), where z_i is bit 63−i of 0xFA2561CDF44AC398.
  - Round i uses key k[4·(i/4) + ((i mod 4 + lane) mod 4)].
  - Each round computes left' = right ^ ((rol1(left) & rol8(left)) ^ rol2(left)) ^ key, then right' = left.
  - After 32 rounds the output is {right, left}.
- R5: The lanes map to quarters as follows: H[63:32] uses lane 0, H[31:0] uses lane 1, L[63:32] uses lane 2 and L[31:0] uses lane 3. The digest is {c0 ^ c2, c1 ^ c3}, where cN is the lane-N result.
- R6: All four encryptions of one computation use the key captured at `start`.
- R7: When `start` is sampled high while idle at edge n, `done` is high only for the cycle following edge n+4.
- R8: `opA`, `opB` and `hashKey` are sampled only at the accepting edge. Later changes do not alter the result.
- R9: A `start` sampled while a computation is in progress is ignored. It neither changes the result nor causes an extra `done`.
- R10: `digest` changes only in a cycle where `done` is high. A `start` in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a new digest (accepted when idle) |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| hashKey | input | 64 | Secret key |
| done | output | 1 | One-cycle completion pulse |
| digest | output | 64 | Resulting tag, held until the next completion |

## Verification
Two events can fall in the same cycle: the completion of one digest and the acceptance of the next request. The bench raises `start` in the exact cycle where `done` is high. It then checks two things: the old digest stays on the output through the whole next run, and the new tag appears four cycles later. The bench also holds `start` high throughout a run while it changes the operands. Only the first request's tag and a single `done` pulse may appear.

// File: rtl/hashDigestPkg.sv
package hashDigestPkg;
  localparam int WORD_W = 16;
  localparam int BLOCK_W = 2 * WORD_W;
  localparam int DATA_W = 64;
  localparam int NUM_LANES = 4;
  localparam int LANE_W = $clog2(NUM_LANES);
  localparam logic [WORD_W-1:0] SCHED_C = 16'hFFFC;
  localparam logic [63:0] SCHED_Z = 64'hFA2561CDF44AC398;

  typedef struct packed {
    logic load;
    logic step;
    logic finish;
    logic [LANE_W-1:0] lane;
  } ctrlStrobes_t;

  function automatic logic [WORD_W-1:0] rotL(input logic [WORD_W-1:0] v, input int n);
    return (v << n) | (v >> (WORD_W - n));
  endfunction

  function automatic logic [WORD_W-1:0] rotR(input logic [WORD_W-1:0] v, input int n);
    return (v >> n) | (v << (WORD_W - n));
  endfunction
endpackage

// File: rtl/hashCipher.sv
module hashCipher
  import hashDigestPkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic [BLOCK_W-1:0] blockIn,
  input  logic [DATA_W-1:0]  keyIn,
  input  logic [LANE_W-1:0]  lane,
  output logic [BLOCK_W-1:0] blockOut
);
  localparam int GROUPS = ROUNDS / 4;

  logic [WORD_W-1:0] ks [ROUNDS];
  logic [WORD_W-1:0] effK [ROUNDS];
  logic [WORD_W-1:0] xl [ROUNDS+1];
  logic [WORD_W-1:0] xr [ROUNDS+1];

  // base keys: most significant word first
  genvar g;
  generate
    for (g = 0; g < 4; g++) begin : gBase
      assign ks[g] = keyIn[DATA_W-1-WORD_W*g -: WORD_W];
    end
    for (g = 0; g < ROUNDS - 4; g++) begin : gSched
      logic [WORD_W-1:0] tmp;
      assign tmp = rotR(ks[g+3], 3) ^ ks[g+1];
      assign ks[g+4] = SCHED_C ^ {{(WORD_W-1){1'b0}}, SCHED_Z[63-g]} ^ ks[g] ^ tmp ^ rotR(tmp, 1);
    end
    for (g = 0; g < GROUPS; g++) begin : gLaneRot
      logic [4*WORD_W-1:0] grp;
      assign grp = {ks[4*g+3], ks[4*g+2], ks[4*g+1], ks[4*g]};
      for (genvar j = 0; j < 4; j++) begin : gPick
        logic [LANE_W-1:0] idx;
        assign idx = LANE_W'(j) + lane;
        assign effK[4*g+j] = grp[idx*WORD_W +: WORD_W];
      end
    end
  endgenerate

  assign xl[0] = blockIn[WORD_W-1:0];
  assign xr[0] = blockIn[BLOCK_W-1:WORD_W];

  generate
    for (g = 0; g < ROUNDS; g++) begin : gRound
      logic [WORD_W-1:0] fx;
      assign fx = (rotL(xl[g], 1) & rotL(xl[g], 8)) ^ rotL(xl[g], 2);
      assign xl[g+1] = xr[g] ^ fx ^ effK[g];
      assign xr[g+1] = xl[g];
    end
  endgenerate

  assign blockOut = {xr[ROUNDS], xl[ROUNDS]};
endmodule

// File: rtl/hashControl.sv
module hashControl
  import hashDigestPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  output ctrlStrobes_t ctrl,
  output logic         done
);
  typedef enum logic {ST_IDLE, ST_RUN} state_t;

  state_t stateQ;
  logic [LANE_W-1:0] laneQ;
  logic lastLane;

  assign lastLane = (laneQ == LANE_W'(NUM_LANES - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      laneQ <= '0;
      done <= 1'b0;
    end else begin
      done <= (stateQ == ST_RUN) && lastLane;
      case (stateQ)
        ST_IDLE: begin
          laneQ <= '0;
          if (start) stateQ <= ST_RUN;
        end
        default: begin
          laneQ <= laneQ + 1'b1;
          if (lastLane) stateQ <= ST_IDLE;
        end
      endcase
    end
  end

  always_comb begin
    ctrl.load = (stateQ == ST_IDLE) && start;
    ctrl.step = (stateQ == ST_RUN);
    ctrl.finish = (stateQ == ST_RUN) && lastLane;
    ctrl.lane = laneQ;
  end
endmodule

// File: rtl/hashDatapath.sv
module hashDatapath
  import hashDigestPkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctrl,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [DATA_W-1:0] hashKey,
  output logic [DATA_W-1:0] digest
);
  logic [DATA_W-1:0] stageH, stageL, hQ, lQ, keyQ, accQ;
  logic [BLOCK_W-1:0] cipherIn, cipherOut;

  // byte weave: second operand descends through odd slots, first operand ascends through even slots
  always_comb begin
    stageH = '0;
    stageL = '0;
    for (int i = 0; i < 4; i++) begin
      stageH[8*(7-2*i) +: 8] = opB[8*i +: 8];
      stageH[8*(2*i) +: 8]   = opA[8*(4+i) +: 8];
      stageL[8*(7-2*i) +: 8] = opB[8*(4+i) +: 8];
      stageL[8*(2*i) +: 8]   = opA[8*i +: 8];
    end
  end

  always_comb begin
    case (ctrl.lane)
      2'd0:    cipherIn = hQ[63:32];
      2'd1:    cipherIn = hQ[31:0];
      2'd2:    cipherIn = lQ[63:32];
      default: cipherIn = lQ[31:0];
    endcase
  end

  hashCipher #(.ROUNDS(ROUNDS)) u_cipher (
    .blockIn (cipherIn),
    .keyIn   (keyQ),
    .lane    (ctrl.lane),
    .blockOut(cipherOut)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hQ <= '0;
      lQ <= '0;
      keyQ <= '0;
      accQ <= '0;
      digest <= '0;
    end else begin
      if (ctrl.load) begin
        hQ <= stageH;
        lQ <= stageL;
        keyQ <= hashKey;
      end
      if (ctrl.step) begin
        // lane bit0 picks the half, lane bit1 picks load or fold
        case (ctrl.lane)
          2'd0:    accQ[63:32] <= cipherOut;
          2'd1:    accQ[31:0] <= cipherOut;
          2'd2:    accQ[63:32] <= accQ[63:32] ^ cipherOut;
          default: accQ[31:0] <= accQ[31:0] ^ cipherOut;
        endcase
      end
      if (ctrl.finish) digest <= {accQ[63:32], accQ[31:0] ^ cipherOut};
    end
  end
endmodule

// File: rtl/hashDigestUnit.sv
module hashDigestUnit
  import hashDigestPkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  input  logic [63:0] hashKey,
  output logic        done,
  output logic [63:0] digest
);
  ctrlStrobes_t ctrlBus;

  hashControl u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .start(start),
    .ctrl (ctrlBus),
    .done (done)
  );

  hashDatapath #(.ROUNDS(ROUNDS)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrlBus),
    .opA    (opA),
    .opB    (opB),
    .hashKey(hashKey),
    .digest (digest)
  );
endmodule

// File: rtl/hashDigestChecker.sv
module hashDigestChecker (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        load,
  input logic        done,
  input logic [63:0] digest
);
  // independent run counter: 0 idle, 1..4 run phases
  logic [2:0] chkCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chkCnt <= '0;
    else if (chkCnt == 3'd0) chkCnt <= start ? 3'd1 : 3'd0;
    else if (chkCnt == 3'd4) chkCnt <= 3'd0;
    else chkCnt <= chkCnt + 3'd1;
  end

  always_comb begin
    if (!rstN) AST_RESET_QUIET: assert (!done) else $error("done during reset"); // R1
  end

  AST_DONE_AFTER_FOUR: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt == 3'd4) |=> done); // R7
  AST_NO_STRAY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (chkCnt != 3'd4) |=> !done); // R9
  AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    load |-> (chkCnt == 3'd0)); // R8
  AST_DIGEST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(digest) |-> done); // R10
endmodule

bind hashDigestUnit hashDigestChecker u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .start (start),
  .load  (ctrlBus.load),
  .done  (done),
  .digest(digest)
);

// File: tb/hashDigestUnit_bench.sv
module hashDigestUnit_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [63:0] opA = '0, opB = '0, hashKey = '0;
  logic done;
  logic [63:0] digest;
  int checks = 0;
  int fails = 0;

  always #5 clk = ~clk;

  hashDigestUnit u_hashDigestUnit (
    .clk(clk), .rstN(rstN), .start(start), .opA(opA), .opB(opB),
    .hashKey(hashKey), .done(done), .digest(digest)
  );

  function automatic logic [15:0] rl(logic [15:0] v, int n);
    return (v << n) | (v >> (16 - n));
  endfunction
  function automatic logic [15:0] rr(logic [15:0] v, int n);
    return (v >> n) | (v << (16 - n));
  endfunction

  function automatic logic [31:0] refCipher(logic [31:0] x, logic [63:0] k64, int lane);
    logic [15:0] k [32];
    logic [15:0] l, r, t, e;
    logic [63:0] zc = 64'hFA2561CDF44AC398;
    for (int i = 0; i < 4; i++) k[i] = k64[63-16*i -: 16];
    for (int i = 0; i < 28; i++) begin
      t = rr(k[i+3], 3) ^ k[i+1];
      k[i+4] = 16'hFFFC ^ {15'd0, zc[63-i]} ^ k[i] ^ t ^ rr(t, 1);
    end
    l = x[15:0];
    r = x[31:16];
    for (int i = 0; i < 32; i++) begin
      e = k[4*(i/4) + ((i%4 + lane) % 4)];
      t = l;
      l = r ^ ((rl(l, 1) & rl(l, 8)) ^ rl(l, 2)) ^ e;
      r = t;
    end
    return {r, l};
  endfunction

  function automatic logic [63:0] refDigest(logic [63:0] a, logic [63:0] b, logic [63:0] k);
    logic [63:0] h = '0, lo = '0;
    for (int i = 0; i < 4; i++) begin
      h[8*(7-2*i) +: 8] = b[8*i +: 8];
      h[16*i +: 8] = a[8*(4+i) +: 8];
      lo[8*(7-2*i) +: 8] = b[8*(4+i) +: 8];
      lo[16*i +: 8] = a[8*i +: 8];
    end
    return {refCipher(h[63:32], k, 0) ^ refCipher(lo[63:32], k, 2),
            refCipher(h[31:0], k, 1) ^ refCipher(lo[31:0], k, 3)};
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom(), $urandom()};
  endfunction

  // called at a negedge; leaves the bench at the negedge after the done cycle
  task automatic runOne(logic [63:0] a, logic [63:0] b, logic [63:0] k, string tag);
    logic [63:0] exp = refDigest(a, b, k);
    opA = a; opB = b; hashKey = k; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opA = rnd64(); opB = rnd64(); hashKey = rnd64(); // R8: scrambled after capture
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      chk("R7 done early", 64'(done), 64'd0);
    end
    @(negedge clk);
    chk("R7 done on time", 64'(done), 64'd1);
    chk(tag, digest, exp);
    @(negedge clk);
    chk("R7 done single pulse", 64'(done), 64'd0);
  endtask

  initial begin
    logic [63:0] expA, expC, old;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R1 done in reset", 64'(done), 64'd0);
    chk("R1 digest in reset", digest, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    runOne('0, '0, '0, "R4 R5 zero vector");
    runOne('1, '1, '1, "R4 R5 all ones");
    runOne(64'h0102030405060708, '0, '0, "R2 R3 first operand weave");
    runOne('0, 64'h1122334455667788, '0, "R2 R3 second operand weave");
    runOne('0, '0, 64'h0123456789ABCDEF, "R4 R6 key schedule");
    runOne(64'hDEADBEEF00000000, 64'h00000000CAFEF00D, 64'h8000000000000001, "R5 lane mapping");
    for (int n = 0; n < 20; n++) runOne(rnd64(), rnd64(), rnd64(), "R8 R6 random vector");

    // R9: start held high and inputs changed during a run
    opA = rnd64(); opB = rnd64(); hashKey = rnd64();
    expA = refDigest(opA, opB, hashKey);
    start = 1'b1;
    @(negedge clk);
    opA = rnd64(); opB = rnd64(); hashKey = rnd64();
    @(negedge clk); chk("R9 no early done", 64'(done), 64'd0);
    @(negedge clk); chk("R9 no early done", 64'(done), 64'd0);
    @(negedge clk); chk("R9 no early done", 64'(done), 64'd0);
    start = 1'b0;
    @(negedge clk);
    chk("R9 done once", 64'(done), 64'd1);
    chk("R9 first request result", digest, expA);
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R9 no extra done", 64'(done), 64'd0);
    end

    // R10: new start in the done cycle
    opA = rnd64(); opB = rnd64(); hashKey = rnd64();
    expA = refDigest(opA, opB, hashKey);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk("R10 first done", 64'(done), 64'd1);
    chk("R10 first digest", digest, expA);
    old = digest;
    opA = rnd64(); opB = rnd64(); hashKey = rnd64();
    expC = refDigest(opA, opB, hashKey);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= 3; c++) begin
      @(negedge clk);
      chk("R10 digest held", digest, old);
    end
    @(negedge clk);
    chk("R10 back-to-back done", 64'(done), 64'd1);
    chk("R10 back-to-back digest", digest, expC);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule